// File: doc/BRIEF.md
# Sparse-Code Seven-Segment Decoder

This block turns a 4-bit switch word into the segment pattern of one seven-segment digit. The switch word is read as a sparse code rather than as a binary number. An all-clear word shows 0. A word with exactly one bit set shows the digit for that bit's position plus one, so bits 0 to 3 show 1 to 4. Every other word shows the letter F as an error glyph.

The block also drives the digit-enable lines of a four-position display. Only the rightmost position is enabled, and it stays enabled whatever the input. The block is purely combinational: it has no clock and no state. It sits between a bank of switches and the display pins.

Top module: `sparse_seg_decoder`

## Requirements
- R1: Input 4'b0000 drives seg_o to 7'h40, the active-low pattern for digit 0 (segments a, b, c, d, e and f lit).
- R2: Input 4'b0001 drives seg_o to 7'h79 (digit 1: b and c lit). Input 4'b0010 drives 7'h24 (digit 2: a, b, d, e and g lit).
- R3: Input 4'b0100 drives seg_o to 7'h30 (digit 3: a, b, c, d and g lit). Input 4'b1000 drives 7'h19 (digit 4: b, c, f and g lit).
- R4: Every input with two or more bits set drives seg_o to 7'h0E, the letter F (a, e, f and g lit).
- R5: Segment outputs are active-low, with seg_o bit 0 driving segment a and bit 6 driving segment g. Every code value in R1 to R4 assumes this mapping.
- R6: an_o is 4'b1110 for every input. The line for position 0 is low (enabled) and the other three are high.
- R7: seg_o and an_o follow sw_i within the same cycle. No input value leaves them depending on an earlier input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sw_i | input | 4 | Sparse-coded switch word |
| seg_o | output | 7 | Active-low segments; bit 0 is a, bit 6 is g |
| an_o | output | 4 | Active-low digit enables; bit 0 is the rightmost position |

## Verification
Every result of this block is due zero cycles after its stimulus, because no register lies between sw_i and either output. The bench changes sw_i shortly after a rising clock edge. It samples seg_o and an_o at the falling edge that follows, which gives half a period for the logic to settle. Each of the 16 input words is applied in turn with no reset or idle cycle in between. A wrong value therefore cannot be hidden by a leftover from the word before, and this is how R7 is checked.

// File: rtl/sparse_seg_pkg.sv
package sparse_seg_pkg;
  localparam int unsigned SW_W   = 4;
  localparam int unsigned SEG_W  = 7;
  localparam int unsigned GLYPH_W = 3;

  typedef enum logic [GLYPH_W-1:0] {
    GLYPH_0   = 3'd0,
    GLYPH_1   = 3'd1,
    GLYPH_2   = 3'd2,
    GLYPH_3   = 3'd3,
    GLYPH_4   = 3'd4,
    GLYPH_ERR = 3'd7
  } glyph_e;

  // active-high segment masks, bit 0 = a ... bit 6 = g
  function automatic logic [SEG_W-1:0] glyph_mask(glyph_e g);
    logic [SEG_W-1:0] m;
    unique case (g)
      GLYPH_0: m = 7'b011_1111;
      GLYPH_1: m = 7'b000_0110;
      GLYPH_2: m = 7'b101_1011;
      GLYPH_3: m = 7'b100_1111;
      GLYPH_4: m = 7'b110_0110;
      default: m = 7'b111_0001;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sparse_code_classify.sv
module sparse_code_classify
  import sparse_seg_pkg::*;
#(
  parameter int unsigned IN_W = SW_W
) (
  input  logic [IN_W-1:0] code_i,
  output glyph_e          glyph_o
);
  localparam int unsigned CNT_W = $clog2(IN_W + 1);
  localparam int unsigned POS_W = $clog2(IN_W + 1);

  logic [CNT_W-1:0] ones;
  logic [POS_W-1:0] pos;

  // count set bits and remember the highest one (1-based)
  always_comb begin
    ones = '0;
    pos  = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (code_i[i]) begin
        ones = ones + CNT_W'(1);
        pos  = POS_W'(i + 1);
      end
    end
  end

  always_comb begin
    if (ones == '0)       glyph_o = GLYPH_0;
    else if (ones == CNT_W'(1)) glyph_o = glyph_e'(GLYPH_W'(pos));
    else                  glyph_o = GLYPH_ERR;
  end

  always_comb begin
    if (!$isunknown(code_i)) begin
      // R4
      multi_bit_err_chk: assert (($countones(code_i) < 2) || (glyph_o == GLYPH_ERR))
        else $error("multi-bit code not flagged");
      // R2
      single_bit_digit_chk: assert (($countones(code_i) != 1) || (glyph_o != GLYPH_ERR && glyph_o != GLYPH_0))
        else $error("single-bit code lost");
    end
  end
endmodule

// File: rtl/glyph_to_seg.sv
module glyph_to_seg
  import sparse_seg_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  glyph_e           glyph_i,
  output logic [SEG_W-1:0] seg_o
);
  logic [SEG_W-1:0] lit;

  always_comb lit = glyph_mask(glyph_i);

  generate
    if (ACTIVE_LOW) begin : g_low
      assign seg_o = ~lit;
    end else begin : g_high
      assign seg_o = lit;
    end
  endgenerate

  always_comb begin
    if (!$isunknown(glyph_i)) begin
      // R5
      seg_nonblank_chk: assert (lit != '0)
        else $error("blank glyph");
    end
  end
endmodule

// File: rtl/digit_select.sv
module digit_select #(
  parameter int unsigned NUM_DIGITS = 4,
  parameter int unsigned ACTIVE_POS = 0,
  parameter bit          ACTIVE_LOW = 1'b1
) (
  output logic [NUM_DIGITS-1:0] an_o
);
  generate
    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dig
      assign an_o[d] = (d == ACTIVE_POS) ? ~ACTIVE_LOW : ACTIVE_LOW;
    end
  endgenerate
endmodule

// File: rtl/sparse_seg_decoder.sv
module sparse_seg_decoder
  import sparse_seg_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  parameter int unsigned ACTIVE_POS = 0
) (
  input  logic [SW_W-1:0]       sw_i,
  output logic [SEG_W-1:0]      seg_o,
  output logic [NUM_DIGITS-1:0] an_o
);
  glyph_e glyph;

  sparse_code_classify #(.IN_W(SW_W)) u_classify (
    .code_i  (sw_i),
    .glyph_o (glyph)
  );

  glyph_to_seg #(.ACTIVE_LOW(1'b1)) u_seg (
    .glyph_i (glyph),
    .seg_o   (seg_o)
  );

  digit_select #(
    .NUM_DIGITS (NUM_DIGITS),
    .ACTIVE_POS (ACTIVE_POS),
    .ACTIVE_LOW (1'b1)
  ) u_an (
    .an_o (an_o)
  );

  always_comb begin
    // R6
    one_digit_chk: assert ($countones(~an_o) == 1)
      else $error("digit enable not one-hot");
    if (!$isunknown(sw_i)) begin
      // R1
      zero_code_chk: assert ((sw_i != '0) || (seg_o == 7'h40))
        else $error("zero code wrong glyph");
      // R4
      err_glyph_chk: assert (($countones(sw_i) < 2) || (seg_o == 7'h0E))
        else $error("error glyph missing");
    end
  end
endmodule

// File: tb/sparse_seg_decoder_tb_top.sv
`timescale 1ns/1ps
module sparse_seg_decoder_tb_top;
  logic       clk = 1'b0;
  logic [3:0] sw;
  logic [6:0] seg;
  logic [3:0] an;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  sparse_seg_decoder dut_i (
    .sw_i  (sw),
    .seg_o (seg),
    .an_o  (an)
  );

  // reference glyph for digit d (5 = F), active-low, bit0 = a
  function automatic logic [6:0] ref_seg(int d);
    logic [6:0] on;
    case (d)
      0: on = 7'h3F;
      1: on = 7'h06;
      2: on = 7'h5B;
      3: on = 7'h4F;
      4: on = 7'h66;
      default: on = 7'h71;
    endcase
    return ~on;
  endfunction

  function automatic int ref_digit(logic [3:0] v);
    int n = 0;
    int p = 0;
    for (int i = 0; i < 4; i++) if (v[i]) begin n++; p = i + 1; end
    if (n == 0) return 0;
    if (n == 1) return p;
    return 5;
  endfunction

  function automatic string req_of(logic [3:0] v);
    int d = ref_digit(v);
    if (d == 0) return "R1";
    if (d == 1 || d == 2) return "R2";
    if (d == 3 || d == 4) return "R3";
    return "R4";
  endfunction

  task automatic check(string req, logic [3:0] v, logic [6:0] act, logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s sw=%b act=%h exp=%h", req, v, act, exp);
    end
  endtask

  initial begin
    sw = 4'b0000;
    @(negedge clk);
    // R1 R6 state after start
    check("R1", sw, seg, ref_seg(0));
    check("R6", sw, {3'b0, an}, 7'h0E);
    // R5 R7: full sweep, back to back, one cycle per word
    for (int k = 0; k < 16; k++) begin
      @(posedge clk);
      #1 sw = 4'(k);
      @(negedge clk);
      check(req_of(sw), sw, seg, ref_seg(ref_digit(sw)));
      check("R6", sw, {3'b0, an}, 7'h0E);
    end
    // R7: descending order exposes stale outputs
    for (int k = 15; k >= 0; k--) begin
      @(posedge clk);
      #1 sw = 4'(k);
      @(negedge clk);
      check("R7", sw, seg, ref_seg(ref_digit(sw)));
    end
    // R5: segment a alone lit-state for digit 1 is dark (bit 0 high)
    @(posedge clk);
    #1 sw = 4'b0001;
    @(negedge clk);
    check("R5", sw, {6'b0, seg[0]}, 7'h01);
    check("R5", sw, {6'b0, seg[6]}, 7'h01);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule